// File: doc/BRIEF.md
# Radar Chirp Timing Controller

This block sets the timing of radar transmit chirps on one fast clock. When a chirp request arrives while the block is idle, it latches one of three waveform lengths and streams that many 8-bit samples. Each sample comes with a valid strobe. While the chirp runs, the block closes the RF switch and enables the transmit mixer. It then holds a listen phase of fixed length, during which the receive mixer is enabled, and returns to idle.

A 6-bit counter records how many chirps have completed since the last frame pulse. Single-cycle strobes mark the first and the last sample of every chirp. A global mixers-enable acts as a safety override: while it is low, both mixers and the RF switch are off and the sequencer returns to idle. The transmit and receive load lines toward the beamformer are held inactive at all times. The sample values are a simple ramp.

Top module: `chirp_seq_ctrl`

## Requirements
- R1: The waveform select `wave_sel` is latched with the request. Its encoding is 2'b00 = 120 samples, 2'b01 = 600 samples, 2'b10 = 3600 samples, and 2'b11 = 120 samples.
- R2: A request (`chirp_req` high) is taken only when the block is idle and `mix_en` is high. The first sample appears in the cycle after the request edge. `sample_vld` and `rf_sw` are then high for exactly the chosen number of consecutive cycles, and `sample` counts 0, 1, 2 … modulo 256. `sample` is 0 whenever `sample_vld` is low.
- R3: `tx_mix_en` is high only while samples are being sent. `rx_mix_en` is high in every other cycle in which `mix_en` is high. The two are never high together.
- R4: While `mix_en` is low, `tx_mix_en`, `rx_mix_en`, `rf_sw`, `sample_vld` and `chirp_done` are low in that same cycle. At the next edge the sequencer is idle. A chirp cut short this way does not count, and after `mix_en` returns a fresh request is needed.
- R5: `chirp_cnt` increments by one at the edge that ends each completed chirp and wraps from 63 to 0. Otherwise it holds its value.
- R6: `frame_pulse` clears `chirp_cnt` to 0 at the next edge. This holds even when a chirp completes in that same cycle.
- R7: `chirp_start` is high for exactly one cycle, together with the first sample of each chirp.
- R8: `chirp_done` is high for exactly one cycle, together with the last sample of each chirp.
- R9: Every bit of `bf_load_tx` and `bf_load_rx` is low in every cycle.
- R10: During and after reset, with no request, `rf_sw`, `chirp_done`, `sample_vld`, `tx_mix_en` and `chirp_cnt` are 0.
- R11: After the last sample, a listen phase of `LISTEN_LEN` (default 16) cycles follows, and then the block is idle. Requests that arrive during the chirp or the listen phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mix_en | input | 1 | Global mixers-enable and safety override |
| chirp_req | input | 1 | Chirp request from the destination side |
| wave_sel | input | 2 | Waveform length select |
| frame_pulse | input | 1 | Clears the per-frame chirp counter |
| sample | output | SMP_W (8) | Ramp chirp sample |
| sample_vld | output | 1 | Sample strobe |
| chirp_start | output | 1 | First-sample strobe |
| chirp_done | output | 1 | Last-sample strobe |
| rf_sw | output | 1 | RF switch control |
| tx_mix_en | output | 1 | Transmit mixer enable |
| rx_mix_en | output | 1 | Receive mixer enable |
| bf_load_tx | output | NUM_BF (4) | Beamformer transmit load lines (held low) |
| bf_load_rx | output | NUM_BF (4) | Beamformer receive load lines (held low) |
| chirp_cnt | output | CNT_W (6) | Completed chirps in the current frame |

## Verification
Two counter events can land in the same cycle: a chirp completion (`chirp_done`) and a frame pulse. The bench provokes this by watching for `chirp_done` at the falling edge and raising `frame_pulse` in that same cycle. The expected result is a counter of 0, not 1.

A second overlap is a drop of `mix_en` in the middle of a chirp. The mixer outputs must fall in that cycle, and the counter must not move. Both cases are judged against a behavioural model that is compared on every clock.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CHIRP  = 2'd1,
      ST_LISTEN = 2'd2
   } seq_state_t;
endpackage

// File: rtl/chirp_len_sel.sv
module chirp_len_sel #(
   parameter int SHORT_LEN = 120,
   parameter int MED_LEN   = 600,
   parameter int LONG_LEN  = 3600,
   parameter int LEN_W     = 12
) (
   input  logic [1:0]       sel,
   output logic [LEN_W-1:0] len
);
   always_comb begin
      case (sel)
         2'b01:   len = LEN_W'(MED_LEN);
         2'b10:   len = LEN_W'(LONG_LEN);
         default: len = LEN_W'(SHORT_LEN);
      endcase
   end
endmodule

// File: rtl/chirp_phase_fsm.sv
module chirp_phase_fsm
   import chirp_seq_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int LISTEN_LEN = 16,
   parameter int LST_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mix_en,
   input  logic             req,
   input  logic [LEN_W-1:0] sel_len,
   output seq_state_t       state,
   output logic [LEN_W-1:0] idx,
   output logic             last_smp
);
   logic [LEN_W-1:0] len_q;
   logic [LST_W-1:0] lcnt;

   assign last_smp = (state == ST_CHIRP) && (idx == len_q - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !mix_en) begin
         state <= ST_IDLE;
         idx   <= '0;
         lcnt  <= '0;
         if (!rst_n) len_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req) begin
               state <= ST_CHIRP;
               idx   <= '0;
               len_q <= sel_len;
            end
            ST_CHIRP: if (last_smp) begin
               state <= ST_LISTEN;
               lcnt  <= '0;
            end else begin
               idx <= idx + LEN_W'(1);
            end
            ST_LISTEN: if (lcnt == LST_W'(LISTEN_LEN - 1)) begin
               state <= ST_IDLE;
            end else begin
               lcnt <= lcnt + LST_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chirp_frame_cnt.sv
module chirp_frame_cnt #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (inc)      cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/chirp_seq_ctrl.sv
module chirp_seq_ctrl
   import chirp_seq_pkg::*;
#(
   parameter int SHORT_LEN  = 120,
   parameter int MED_LEN    = 600,
   parameter int LONG_LEN   = 3600,
   parameter int LISTEN_LEN = 16,
   parameter int SMP_W      = 8,
   parameter int CNT_W      = 6,
   parameter int NUM_BF     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mix_en,
   input  logic              chirp_req,
   input  logic [1:0]        wave_sel,
   input  logic              frame_pulse,
   output logic [SMP_W-1:0]  sample,
   output logic              sample_vld,
   output logic              chirp_start,
   output logic              chirp_done,
   output logic              rf_sw,
   output logic              tx_mix_en,
   output logic              rx_mix_en,
   output logic [NUM_BF-1:0] bf_load_tx,
   output logic [NUM_BF-1:0] bf_load_rx,
   output logic [CNT_W-1:0]  chirp_cnt
);
   localparam int MAX_LEN = (LONG_LEN > MED_LEN) ?
                            ((LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN) :
                            ((MED_LEN > SHORT_LEN) ? MED_LEN : SHORT_LEN);
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam int LST_W   = $clog2(LISTEN_LEN + 1);

   if (SHORT_LEN < 1 || MED_LEN < 1 || LONG_LEN < 1) begin : g_bad_len
      $error("chirp_seq_ctrl: every chirp length must be at least 1");
   end
   if (LISTEN_LEN < 1) begin : g_bad_listen
      $error("chirp_seq_ctrl: LISTEN_LEN must be at least 1");
   end
   if (SMP_W < 1 || CNT_W < 1 || NUM_BF < 1) begin : g_bad_width
      $error("chirp_seq_ctrl: widths and counts must be positive");
   end

   logic [LEN_W-1:0] sel_len;
   logic [LEN_W-1:0] idx;
   logic             last_smp;
   logic             active;
   logic [SMP_W-1:0] ramp;
   seq_state_t       state;

   chirp_len_sel #(
      .SHORT_LEN(SHORT_LEN), .MED_LEN(MED_LEN), .LONG_LEN(LONG_LEN), .LEN_W(LEN_W)
   ) u_len (
      .sel(wave_sel),
      .len(sel_len)
   );

   chirp_phase_fsm #(
      .LEN_W(LEN_W), .LISTEN_LEN(LISTEN_LEN), .LST_W(LST_W)
   ) u_fsm (
      .clk(clk),
      .rst_n(rst_n),
      .mix_en(mix_en),
      .req(chirp_req),
      .sel_len(sel_len),
      .state(state),
      .idx(idx),
      .last_smp(last_smp)
   );

   chirp_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk),
      .rst_n(rst_n),
      .clr(frame_pulse),
      .inc(chirp_done),
      .cnt(chirp_cnt)
   );

   if (SMP_W <= LEN_W) begin : g_ramp_slice
      assign ramp = idx[SMP_W-1:0];
   end else begin : g_ramp_pad
      assign ramp = {{(SMP_W - LEN_W){1'b0}}, idx};
   end

   assign active      = mix_en && (state == ST_CHIRP);
   assign sample_vld  = active;
   assign sample      = active ? ramp : '0;
   assign rf_sw       = active;
   assign tx_mix_en   = active;
   assign rx_mix_en   = mix_en && (state != ST_CHIRP);
   assign chirp_start = active && (idx == '0);
   assign chirp_done  = mix_en && last_smp;
   assign bf_load_tx  = '0;
   assign bf_load_rx  = '0;
endmodule

// File: rtl/chirp_seq_chk.sv
module chirp_seq_chk #(
   parameter int CNT_W  = 6,
   parameter int NUM_BF = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mix_en,
   input logic              frame_pulse,
   input logic              sample_vld,
   input logic              chirp_start,
   input logic              chirp_done,
   input logic              rf_sw,
   input logic              tx_mix_en,
   input logic              rx_mix_en,
   input logic [NUM_BF-1:0] bf_load_tx,
   input logic [NUM_BF-1:0] bf_load_rx,
   input logic [CNT_W-1:0]  chirp_cnt
);
   p_mix_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_mix_en && rx_mix_en));

   p_safe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_en |-> (!tx_mix_en && !rx_mix_en && !rf_sw && !chirp_done));

   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chirp_done && !frame_pulse) |=> (chirp_cnt == $past(chirp_cnt) + CNT_W'(1)));

   p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!chirp_done && !frame_pulse) |=> $stable(chirp_cnt));

   p_frame_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> (chirp_cnt == '0));

   p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chirp_start |=> !chirp_start);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chirp_done |=> !chirp_done);

   p_done_with_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chirp_done |-> (sample_vld && rf_sw));

   p_loads_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bf_load_tx == '0) && (bf_load_rx == '0));
endmodule

bind chirp_seq_ctrl chirp_seq_chk #(.CNT_W(CNT_W), .NUM_BF(NUM_BF)) u_chk (
   .clk(clk), .rst_n(rst_n), .mix_en(mix_en), .frame_pulse(frame_pulse),
   .sample_vld(sample_vld), .chirp_start(chirp_start), .chirp_done(chirp_done),
   .rf_sw(rf_sw), .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en),
   .bf_load_tx(bf_load_tx), .bf_load_rx(bf_load_rx), .chirp_cnt(chirp_cnt)
);

// File: tb/tb_chirp_seq_ctrl.sv
module tb_chirp_seq_ctrl;
   localparam int LISTEN = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mix_en = 1'b0;
   logic       chirp_req = 1'b0;
   logic [1:0] wave_sel = 2'b00;
   logic       frame_pulse = 1'b0;
   logic [7:0] sample;
   logic       sample_vld, chirp_start, chirp_done, rf_sw, tx_mix_en, rx_mix_en;
   logic [3:0] bf_load_tx, bf_load_rx;
   logic [5:0] chirp_cnt;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int vld_run = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_st = 0;      // 0 idle, 1 chirp, 2 listen
   int m_idx = 0;
   int m_len = 0;
   int m_lc = 0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   chirp_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mix_en(mix_en), .chirp_req(chirp_req),
      .wave_sel(wave_sel), .frame_pulse(frame_pulse), .sample(sample),
      .sample_vld(sample_vld), .chirp_start(chirp_start), .chirp_done(chirp_done),
      .rf_sw(rf_sw), .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en),
      .bf_load_tx(bf_load_tx), .bf_load_rx(bf_load_rx), .chirp_cnt(chirp_cnt)
   );

   function automatic int len_of(input logic [1:0] s);
      case (s)
         2'b01:   return 600;
         2'b10:   return 3600;
         default: return 120;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // reference model update on each rising edge
   always @(posedge clk) begin
      bit done_now;
      cycles++;
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_len = 0; m_lc = 0; m_cnt = 0;
      end else begin
         done_now = mix_en && m_st == 1 && m_idx == m_len - 1;
         if (frame_pulse) m_cnt = 0;
         else if (done_now) m_cnt = (m_cnt + 1) % 64;
         if (!mix_en) begin
            m_st = 0; m_idx = 0; m_lc = 0;
         end else if (m_st == 0) begin
            if (chirp_req) begin m_st = 1; m_idx = 0; m_len = len_of(wave_sel); end
         end else if (m_st == 1) begin
            if (m_idx == m_len - 1) begin m_st = 2; m_lc = 0; end
            else m_idx++;
         end else begin
            if (m_lc == LISTEN - 1) m_st = 0;
            else m_lc++;
         end
      end
   end

   // per-cycle comparison, a quarter period after the falling edge
   always begin
      bit act;
      @(negedge clk);
      #5;
      act = mix_en && m_st == 1;
      if (sample_vld) vld_run++;
      chk(sample_vld == act, "R2 sample_vld", sample_vld, act);
      chk(rf_sw == act, "R2 rf_sw", rf_sw, act);
      chk(sample == (act ? m_idx % 256 : 0), "R2 sample", sample, act ? m_idx % 256 : 0);
      chk(tx_mix_en == act, "R3 tx_mix_en", tx_mix_en, act);
      chk(rx_mix_en == (mix_en && m_st != 1), "R3/R4 rx_mix_en", rx_mix_en, mix_en && m_st != 1);
      chk(chirp_start == (act && m_idx == 0), "R7 chirp_start", chirp_start, act && m_idx == 0);
      chk(chirp_done == (act && m_idx == m_len - 1), "R8 chirp_done", chirp_done,
          act && m_idx == m_len - 1);
      chk(chirp_cnt == m_cnt, "R5/R6 chirp_cnt", chirp_cnt, m_cnt);
      chk(bf_load_tx == 0 && bf_load_rx == 0, "R9 loads", {bf_load_tx, bf_load_rx}, 0);
   end

   task automatic pulse_req(input logic [1:0] s);
      @(negedge clk);
      wave_sel = s; chirp_req = 1'b1;
      @(negedge clk);
      chirp_req = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_st != 0);
      @(negedge clk);
   endtask

   task automatic one_chirp(input logic [1:0] s, input string tag);
      pulse_req(s);
      vld_run = 0;
      wait_idle();
      chk(vld_run == len_of(s), tag, vld_run, len_of(s));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #5;
      chk(rf_sw == 0 && chirp_done == 0 && chirp_cnt == 0 && tx_mix_en == 0,
          "R10 reset outputs", {rf_sw, chirp_done, tx_mix_en}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #5;
      chk(chirp_cnt == 0 && sample_vld == 0, "R10 idle after reset", chirp_cnt, 0);
      @(negedge clk);
      mix_en = 1'b1;
      repeat (3) @(negedge clk);

      one_chirp(2'b00, "R1 short length");
      one_chirp(2'b01, "R1 medium length");
      one_chirp(2'b10, "R1 long length");
      one_chirp(2'b11, "R1 code 11 length");
      chk(chirp_cnt == 4, "R5 count after four chirps", chirp_cnt, 4);

      // R11: requests during chirp and listen are ignored
      pulse_req(2'b00);
      repeat (20) @(negedge clk);
      chirp_req = 1'b1; wave_sel = 2'b10;
      @(negedge clk); chirp_req = 1'b0;
      do @(negedge clk); while (m_st != 2);
      chirp_req = 1'b1;
      @(negedge clk); chirp_req = 1'b0;
      wait_idle();
      chk(chirp_cnt == 5, "R11 ignored requests add no chirp", chirp_cnt, 5);

      // R4: safety override mid-chirp
      pulse_req(2'b01);
      repeat (50) @(negedge clk);
      mix_en = 1'b0;
      #5;
      chk(tx_mix_en == 0 && rx_mix_en == 0 && rf_sw == 0, "R4 override same cycle",
          {tx_mix_en, rx_mix_en, rf_sw}, 0);
      repeat (5) @(negedge clk);
      mix_en = 1'b1;
      repeat (10) @(negedge clk);
      #5;
      chk(sample_vld == 0 && chirp_cnt == 5, "R4 stays idle, no count", chirp_cnt, 5);

      // R6: frame pulse alone
      @(negedge clk); frame_pulse = 1'b1;
      @(negedge clk); frame_pulse = 1'b0;
      #5;
      chk(chirp_cnt == 0, "R6 frame pulse clears", chirp_cnt, 0);
      one_chirp(2'b00, "R1 short after clear");

      // R6: frame pulse coincident with chirp completion
      pulse_req(2'b00);
      do @(negedge clk); while (!chirp_done);
      frame_pulse = 1'b1;
      @(negedge clk); frame_pulse = 1'b0;
      #5;
      chk(chirp_cnt == 0, "R6 coincident pulse wins", chirp_cnt, 0);
      wait_idle();

      // R5: wrap from 63 to 0
      for (int k = 0; k < 63; k++) one_chirp(2'b00, "R1 short in wrap run");
      chk(chirp_cnt == 63, "R5 count reaches 63", chirp_cnt, 63);
      one_chirp(2'b00, "R1 short wrap chirp");
      chk(chirp_cnt == 0, "R5 wrap to 0", chirp_cnt, 0);

      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (190000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule